// File: doc/BRIEF.md
# Double-Buffered Beam Channel Control Register

This block is the serial control front end of one transmit beamforming channel. A host sends a 16-bit frame over a four-wire serial link. The link has a serial clock, an active-low select, data in and data out. While select is low, the block shifts the frame in, most significant bit first. When select rises, the block decodes the two leading command bits.

A write command places an 8-bit amplitude and a 6-bit phase-angle step into a shadow buffer. The values that feed the output stage stay as they were. A separate load strobe later copies the shadow buffer into the active amplitude and angle outputs. Because of this split, the host can update many channels one at a time and then switch all of them together with one load edge.

The block also decodes three other commands:
- A read command asks for the shadow buffer to be shifted out during the next frame.
- A sleep command latches a power-down state.
- A no-op command only wakes the block.

The block adds two protections:
- A frame of the wrong length is thrown away.
- An angle step beyond the valid range is refused and raises a sticky error output.

All serial pins are sampled by the block's system clock through synchronizers. The serial clock must therefore run several times slower than the system clock.

Top module: `beam_ctl_regs`

## Requirements
- R1: After reset, the outputs are: amplitude 0, angle 0, `sleep_out` 0, `angle_err` 0, `ser_dout` 0. `out_en` is all ones while `drive_en` is high. The shadow buffer reads back as amplitude 0, angle 0.
- R2: A frame is received MSB first on rising serial-clock edges. Bits [15:14] are the command, bits [13:6] the amplitude and bits [5:0] the angle step. Command 2'b00 writes amplitude and angle into the shadow buffer only. The active outputs do not change until a load edge.
- R3: A rising edge on `load_stb` copies the shadow buffer into `amp_out` and `angle_out`. These outputs change at no other time.
- R4: When select rises after any number of serial-clock rising edges other than 16, the frame is discarded. The shadow buffer, the sleep state and the read request are all left unchanged.
- R5: Angle steps 48 to 63 are reserved. A write that carries one keeps the old buffered angle but still stores the amplitude. It also sets `angle_err`, which stays set until reset. Buffered and active angles are therefore always below 48.
- R6: Command 2'b01 requests a read. During the next frame, `ser_dout` carries {2'b01, buffered amplitude, buffered angle}, MSB first. The MSB is valid once select falls, and each later bit appears after a falling serial-clock edge. When no read is pending, `ser_dout` is 0.
- R7: Command 2'b10 sets `sleep_out` and drives `out_en` to all zeros. Any other command in a valid frame clears `sleep_out`.
- R8: While `drive_en` is low, every bit of `out_en` is 0, whatever the register contents.
- R9: Command 2'b11 leaves the shadow buffer and the active outputs unchanged. Its only effect is to wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples every serial pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data in is taken on its rising edge |
| ser_sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial data out for read-back |
| load_stb | input | 1 | Rising edge transfers the shadow buffer to the active outputs |
| drive_en | input | 1 | Low forces every channel enable off |
| amp_out | output | AMP_W (8) | Active amplitude code |
| angle_out | output | ANG_W (6) | Active phase-angle step |
| out_en | output | N_CHAN (2) | Per-channel drive enable |
| sleep_out | output | 1 | Latched power-down state |
| angle_err | output | 1 | Sticky flag for a refused reserved angle |

## Verification
Errors in the shadow buffer do not reach `amp_out` and `angle_out`; they appear only after the next load edge, or on `ser_dout` in the frame that follows a read request. For this reason the bench sweeps all 64 angle codes through write, check before load and check after load, and it reads the buffer back at regular points in the sweep. A wrong frame-length count, or a command decode applied to a discarded frame, shows up as a buffer that changed on read-back, or as a `sleep_out` that toggled, once select has risen. A stuck sleep or error state is visible on `out_en` or `angle_err` within a few system clocks of the select edge.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam int CMD_W = 2;

   typedef enum logic [CMD_W-1:0] {
      CMD_WRITE = 2'b00,
      CMD_READ  = 2'b01,
      CMD_SLEEP = 2'b10,
      CMD_IDLE  = 2'b11
   } bcr_cmd_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("bcr_sync needs at least two stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= pipe[STAGES-1];
   end

   assign lvl  = pipe[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/bcr_shift.sv
module bcr_shift #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_rise,
   input  logic               sck_fall,
   input  logic               sel_lvl,
   input  logic               sel_fall,
   input  logic               din,
   input  logic [FRAME_W-1:0] tx_word,
   output logic [FRAME_W-1:0] rx_word,
   output logic               frame_full,
   output logic               dout
);
   localparam int             CNT_W   = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] tx_q;

   if (FRAME_W < 2) begin : g_bad_frame
      $error("bcr_shift frame too short");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rx_word <= '0;
      end else if (sel_fall) begin
         cnt     <= '0;
         rx_word <= '0;
      end else if (!sel_lvl && sck_rise) begin
         rx_word <= {rx_word[FRAME_W-2:0], din};
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tx_q <= '0;
      else if (sel_fall)             tx_q <= tx_word;
      else if (!sel_lvl && sck_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
   end

   assign frame_full = (cnt == CNT_OK);
   assign dout       = ~sel_lvl & tx_q[FRAME_W-1];
endmodule

// File: rtl/bcr_cmd_regs.sv
module bcr_cmd_regs
   import bcr_pkg::*;
#(
   parameter int AMP_W     = 8,
   parameter int ANG_W     = 6,
   parameter int ANG_STEPS = 48
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             sel_rise,
   input  logic                             sel_fall,
   input  logic                             frame_full,
   input  logic [CMD_W+AMP_W+ANG_W-1:0]     rx_word,
   output logic [AMP_W-1:0]                 buf_amp,
   output logic [ANG_W-1:0]                 buf_ang,
   output logic                             sleep,
   output logic                             err,
   output logic                             rd_pend
);
   localparam int               FRAME_W  = CMD_W + AMP_W + ANG_W;
   localparam logic [ANG_W:0]   STEP_LIM = ANG_STEPS[ANG_W:0];

   bcr_cmd_e           cmd;
   logic [AMP_W-1:0]   f_amp;
   logic [ANG_W-1:0]   f_ang;
   logic               take;
   logic               ang_ok;

   always_comb begin
      cmd    = bcr_cmd_e'(rx_word[FRAME_W-1 -: CMD_W]);
      f_amp  = rx_word[ANG_W +: AMP_W];
      f_ang  = rx_word[ANG_W-1:0];
      take   = sel_rise & frame_full;
      ang_ok = ({1'b0, f_ang} < STEP_LIM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_amp <= '0;
         buf_ang <= '0;
         sleep   <= 1'b0;
         err     <= 1'b0;
      end else if (take) begin
         sleep <= (cmd == CMD_SLEEP);
         if (cmd == CMD_WRITE) begin
            buf_amp <= f_amp;
            if (ang_ok) buf_ang <= f_ang;
            else        err     <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rd_pend <= 1'b0;
      else if (sel_fall)                  rd_pend <= 1'b0;
      else if (take && cmd == CMD_READ)   rd_pend <= 1'b1;
   end
endmodule

// File: rtl/beam_ctl_regs.sv
module beam_ctl_regs
   import bcr_pkg::*;
#(
   parameter int AMP_W       = 8,
   parameter int ANG_W       = 6,
   parameter int ANG_STEPS   = 48,
   parameter int SYNC_STAGES = 2,
   parameter int N_CHAN      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_sel_n,
   input  logic              ser_din,
   output logic              ser_dout,
   input  logic              load_stb,
   input  logic              drive_en,
   output logic [AMP_W-1:0]  amp_out,
   output logic [ANG_W-1:0]  angle_out,
   output logic [N_CHAN-1:0] out_en,
   output logic              sleep_out,
   output logic              angle_err
);
   localparam int FRAME_W = CMD_W + AMP_W + ANG_W;

   if (ANG_STEPS < 1 || ANG_STEPS > (1 << ANG_W)) begin : g_bad_steps
      $error("ANG_STEPS does not fit the angle field");
   end
   if (N_CHAN < 1) begin : g_bad_chan
      $error("N_CHAN must be positive");
   end

   logic sck_lvl, sck_rise, sck_fall;
   logic sel_lvl, sel_rise, sel_fall;
   logic din_lvl, din_rise, din_fall;
   logic load_lvl, load_rise, load_fall;

   bcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_clk),
      .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));
   bcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_sel_n),
      .lvl(sel_lvl), .rise(sel_rise), .fall(sel_fall));
   bcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_din),
      .lvl(din_lvl), .rise(din_rise), .fall(din_fall));
   bcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_load_sync (
      .clk(clk), .rst_n(rst_n), .d(load_stb),
      .lvl(load_lvl), .rise(load_rise), .fall(load_fall));

   logic [FRAME_W-1:0] rx_word;
   logic [FRAME_W-1:0] tx_word;
   logic               frame_full;
   logic [AMP_W-1:0]   buf_amp;
   logic [ANG_W-1:0]   buf_ang;
   logic               rd_pend;

   assign tx_word = rd_pend ? {CMD_READ, buf_amp, buf_ang} : '0;

   bcr_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .sel_lvl(sel_lvl), .sel_fall(sel_fall),
      .din(din_lvl), .tx_word(tx_word),
      .rx_word(rx_word), .frame_full(frame_full), .dout(ser_dout));

   bcr_cmd_regs #(.AMP_W(AMP_W), .ANG_W(ANG_W), .ANG_STEPS(ANG_STEPS)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .sel_rise(sel_rise), .sel_fall(sel_fall),
      .frame_full(frame_full), .rx_word(rx_word),
      .buf_amp(buf_amp), .buf_ang(buf_ang),
      .sleep(sleep_out), .err(angle_err), .rd_pend(rd_pend));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_out   <= '0;
         angle_out <= '0;
      end else if (load_rise) begin
         amp_out   <= buf_amp;
         angle_out <= buf_ang;
      end
   end

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      assign out_en[c] = drive_en & ~sleep_out;
   end
endmodule

// File: rtl/beam_ctl_regs_chk.sv
module beam_ctl_regs_chk #(
   parameter int AMP_W     = 8,
   parameter int ANG_W     = 6,
   parameter int ANG_STEPS = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_rise,
   input logic             sel_rise,
   input logic [AMP_W-1:0] buf_amp,
   input logic [ANG_W-1:0] buf_ang,
   input logic [AMP_W-1:0] amp_out,
   input logic [ANG_W-1:0] angle_out,
   input logic             sleep_out,
   input logic             angle_err
);
   localparam logic [ANG_W:0] STEP_LIM = ANG_STEPS[ANG_W:0];

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_rise |=> ($stable(amp_out) && $stable(angle_out))); // R3
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise |=> (amp_out == $past(buf_amp) && angle_out == $past(buf_ang))); // R3
   AST_BUF_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_rise |=> ($stable(buf_amp) && $stable(buf_ang))); // R2
   AST_SLEEP_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_rise |=> $stable(sleep_out)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      angle_err |=> angle_err); // R5
   AST_ANGLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, buf_ang} < STEP_LIM) && ({1'b0, angle_out} < STEP_LIM)); // R5
endmodule

bind beam_ctl_regs beam_ctl_regs_chk #(
   .AMP_W(AMP_W), .ANG_W(ANG_W), .ANG_STEPS(ANG_STEPS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .load_rise(load_rise), .sel_rise(sel_rise),
   .buf_amp(buf_amp), .buf_ang(buf_ang),
   .amp_out(amp_out), .angle_out(angle_out),
   .sleep_out(sleep_out), .angle_err(angle_err));

// File: tb/beam_ctl_regs_bench.sv
module beam_ctl_regs_bench;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       sel_n = 1'b1;
   logic       din = 1'b0;
   logic       dout;
   logic       load = 1'b0;
   logic       drv = 1'b1;
   logic [7:0] amp_out;
   logic [5:0] angle_out;
   logic [1:0] out_en;
   logic       sleep_out;
   logic       angle_err;

   int n_chk = 0;
   int n_bad = 0;
   int bamp = 0, bang = 0, aamp = 0, aang = 0;
   bit err_m = 1'b0;

   always #4 clk = ~clk;

   beam_ctl_regs u_beam_ctl_regs (
      .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_sel_n(sel_n),
      .ser_din(din), .ser_dout(dout), .load_stb(load), .drive_en(drv),
      .amp_out(amp_out), .angle_out(angle_out), .out_en(out_en),
      .sleep_out(sleep_out), .angle_err(angle_err));

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input int nbits, output logic [15:0] rx);
      rx = '0;
      sel_n = 1'b0;
      waitc(HALF);
      for (int i = 0; i < nbits; i++) begin
         din = (i < 16) ? w[15-i] : 1'b0;
         waitc(HALF);
         if (i < 16) rx[15-i] = dout;
         sck = 1'b1;
         waitc(HALF);
         sck = 1'b0;
      end
      waitc(HALF);
      sel_n = 1'b1;
      waitc(8);
   endtask

   task automatic pulse_load();
      load = 1'b1;
      waitc(HALF);
      load = 1'b0;
      waitc(HALF);
      aamp = bamp;
      aang = bang;
   endtask

   task automatic readback(input string req);
      logic [15:0] rx;
      send({2'b01, 14'h0}, 16, rx);
      chk("R6", "idle dout during read frame", int'(rx), 0);
      send({2'b11, 14'h3FFF}, 16, rx);
      chk(req, "read-back word", int'(rx), int'({2'b01, bamp[7:0], bang[5:0]}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      logic [15:0] rx;
      int a_val;
      waitc(5);
      rst_n = 1'b1;
      waitc(5);
      // R1 reset state
      chk("R1", "amp", int'(amp_out), 0);
      chk("R1", "angle", int'(angle_out), 0);
      chk("R1", "out_en", int'(out_en), 3);
      chk("R1", "sleep", int'(sleep_out), 0);
      chk("R1", "err", int'(angle_err), 0);
      chk("R1", "dout", int'(dout), 0);
      readback("R1");

      // R2 R3 R5 sweep of every angle code
      for (int a = 0; a < 64; a++) begin
         a_val = (a * 37 + 11) & 255;
         send({2'b00, a_val[7:0], a[5:0]}, 16, rx);
         bamp = a_val;
         if (a < 48) bang = a;
         else        err_m = 1'b1;
         chk("R2", "amp before load", int'(amp_out), aamp);
         chk("R2", "angle before load", int'(angle_out), aang);
         chk("R5", "err flag", int'(angle_err), int'(err_m));
         pulse_load();
         chk("R3", "amp after load", int'(amp_out), aamp);
         chk("R3", "angle after load", int'(angle_out), aang);
         if (a % 8 == 7) readback("R5");
      end

      // R4 wrong-length frames
      send({2'b00, 8'h5A, 6'd5}, 15, rx);
      readback("R4");
      send({2'b00, 8'hA5, 6'd9}, 17, rx);
      readback("R4");
      send({2'b10, 14'h0}, 15, rx);
      chk("R4", "sleep after short frame", int'(sleep_out), 0);
      send({2'b01, 14'h0}, 17, rx);
      send({2'b11, 14'h0}, 16, rx);
      chk("R4", "no read from long frame", int'(rx), 0);

      // R7 sleep and wake
      send({2'b10, 14'h0}, 16, rx);
      chk("R7", "sleep set", int'(sleep_out), 1);
      chk("R7", "out_en off", int'(out_en), 0);
      send({2'b00, 8'h3C, 6'd17}, 17, rx);
      chk("R4", "sleep kept after long frame", int'(sleep_out), 1);
      send({2'b11, 8'hFF, 6'd3}, 16, rx);
      chk("R9", "nop wakes", int'(sleep_out), 0);
      chk("R9", "out_en back", int'(out_en), 3);
      chk("R9", "amp unchanged", int'(amp_out), aamp);
      readback("R9");
      send({2'b10, 14'h0}, 16, rx);
      send({2'b00, 8'h81, 6'd47}, 16, rx);
      bamp = 8'h81;
      bang = 47;
      chk("R7", "write wakes", int'(sleep_out), 0);
      pulse_load();
      chk("R3", "top angle", int'(angle_out), 47);

      // R8 drive enable gating
      drv = 1'b0;
      waitc(2);
      chk("R8", "out_en with drive off", int'(out_en), 0);
      drv = 1'b1;
      waitc(2);
      chk("R8", "out_en with drive on", int'(out_en), 3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule